// File: doc/BRIEF.md
# Interrupt Entry Context Capture Unit

This block performs the register-level work of entering and leaving an exception or interrupt handler without any memory traffic. When an arbitrated request is accepted, it captures the interrupted program counter, stack pointer, status word and mode into a shadow register set. It forms the handler start address from a software-written vector base and the request priority. It also decides whether the stack pointer must be replaced by the privileged stack pointer.

There is one shadow set for each privilege level, so a nested entry at another level leaves the context saved at a lower level intact. On exit, the shadow set belonging to the handler's current level is presented in one registered step so that the restore path can reload PC, SP, status and mode. Mode encoding is 0 = user, 1 = supervisor, 2 = hypervisor, 3 = secure. Arbitration, trap-cause decoding and memory are outside this block.

Top module: `irq_ctx_unit`

## Requirements
- R1: After reset, req_ready is 1, ent_valid and ret_valid are 0, every shadow set reads as all zeros, and the vector base holds BASE_RST (default 0).
- R2: A request is accepted at a clock edge where req_valid and req_ready are both 1. req_ready equals the inverse of ent_valid. ent_valid is 1 for exactly the one cycle after an acceptance, so a request held high is accepted on every second edge.
- R3: With ent_valid high, new_pc equals the vector base in force before the accepting edge plus (priority << VEC_SHIFT), where VEC_SHIFT defaults to 4.
- R4: A write through base_we/base_wdata updates the vector base only when cur_mode is 1 (supervisor). Writes in any other mode have no effect.
- R5: If the interrupted mode is 0 and the delivered mode is not 0, new_sp is priv_sp. In every other case new_sp is the interrupted cur_sp.
- R6: The delivered mode new_mode is 0 when req_user_ok is 1 and cur_mode is 0. Otherwise it is req_lvl, and req_user_ok has no effect.
- R7: On acceptance, the shadow set indexed by the delivered mode is loaded with cur_pc, cur_sp, cur_status and cur_mode. It can be read combinationally on rd_pc/rd_sp/rd_status/rd_mode, selected by rd_lvl.
- R8: An acceptance writes only the shadow set of its own delivered mode. The sets of all other levels are unchanged.
- R9: exit_valid sampled at an edge makes ret_valid 1 for the next cycle, with ret_pc/ret_sp/ret_status/ret_mode holding the shadow set indexed by cur_mode at that edge.
- R10: When an exit and an acceptance that writes the same level share an edge, the exit returns the contents held before that edge, and the shadow set then holds the new entry's context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Arbitrated interrupt request present |
| req_prio | input | PRIO_W | Priority of the request |
| req_lvl | input | 2 | Target privilege level of the request |
| req_user_ok | input | 1 | User may take this interrupt itself |
| req_ready | output | 1 | Unit can accept a request this cycle |
| cur_pc | input | XLEN | Live program counter |
| cur_sp | input | XLEN | Live stack pointer |
| cur_status | input | ST_W | Live status word |
| cur_mode | input | 2 | Live privilege mode |
| priv_sp | input | XLEN | Privileged stack pointer used on a switch out of user mode |
| base_we | input | 1 | Vector base write strobe |
| base_wdata | input | XLEN | Vector base write value |
| exit_valid | input | 1 | Handler exit request |
| rd_lvl | input | 2 | Shadow set selected for inspection |
| ent_valid | output | 1 | Entry outputs valid this cycle |
| new_pc | output | XLEN | Handler start address |
| new_sp | output | XLEN | Stack pointer for the handler |
| new_mode | output | 2 | Mode the handler runs in |
| ret_valid | output | 1 | Restore outputs valid this cycle |
| ret_pc | output | XLEN | Restored program counter |
| ret_sp | output | XLEN | Restored stack pointer |
| ret_status | output | ST_W | Restored status word |
| ret_mode | output | 2 | Restored mode |
| rd_pc | output | XLEN | Selected shadow set: PC |
| rd_sp | output | XLEN | Selected shadow set: SP |
| rd_status | output | ST_W | Selected shadow set: status |
| rd_mode | output | 2 | Selected shadow set: mode |

## Verification
Two functions can coincide in one cycle: an exit reading a shadow set and an acceptance writing that same set. The bench provokes this by raising exit_valid together with a request whose delivered level equals cur_mode. It judges the result by checking that the returned context is the earlier one while the readback port already shows the new entry. Changes to the vector base that land beside acceptances, and a request held high across several edges, are also driven to confirm which value and which edge take effect.

// File: rtl/irq_ctx_pkg.sv
// Shared privilege-level encoding for the interrupt context unit.
// Assumes exactly four levels; the level count is derived from the enum width.
package irq_ctx_pkg;
    localparam int MODE_W  = 2;
    localparam int NUM_LVL = 1 << MODE_W;

    typedef enum logic [MODE_W-1:0] {
        LV_USER   = 2'd0,
        LV_SUPER  = 2'd1,
        LV_HYPER  = 2'd2,
        LV_SECURE = 2'd3
    } lvl_e;
endpackage

// File: rtl/irq_vec_gen.sv
// Vector base register and handler address generator.
// Holds the base, writable only from supervisor mode, and forms
// base + (prio << VEC_SHIFT). Assumes the caller samples vec_pc at the
// accepting edge, so a base write in the same cycle is not yet visible.
module irq_vec_gen
    import irq_ctx_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int PRIO_W    = 4,
    parameter int VEC_SHIFT = 4,
    parameter logic [XLEN-1:0] BASE_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [XLEN-1:0]   base_wdata,
    input  lvl_e              cur_mode,
    input  logic [PRIO_W-1:0] prio,
    output logic [XLEN-1:0]   base_q,
    output logic [XLEN-1:0]   vec_pc
);
    logic base_wr_ok;

    // Gate base writes to supervisor mode only.
    always_comb base_wr_ok = base_we && (cur_mode == LV_SUPER);

    // Base register update.
    always_ff @(posedge clk) begin
        if (!rst_n)          base_q <= BASE_RST;
        else if (base_wr_ok) base_q <= base_wdata;
    end

    // Handler address from base and priority.
    always_comb vec_pc = base_q + (XLEN'(prio) << VEC_SHIFT);
endmodule

// File: rtl/irq_ctx_bank.sv
// Per-level shadow context storage with one write port and two read ports.
// One set per privilege level, built by a generate loop; reads are
// combinational and return the value held before the current edge.
module irq_ctx_bank
    import irq_ctx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ST_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  lvl_e            wr_lvl,
    input  logic [XLEN-1:0] wr_pc,
    input  logic [XLEN-1:0] wr_sp,
    input  logic [ST_W-1:0] wr_st,
    input  lvl_e            wr_mode,
    input  lvl_e            a_lvl,
    output logic [XLEN-1:0] a_pc,
    output logic [XLEN-1:0] a_sp,
    output logic [ST_W-1:0] a_st,
    output lvl_e            a_mode,
    input  lvl_e            b_lvl,
    output logic [XLEN-1:0] b_pc,
    output logic [XLEN-1:0] b_sp,
    output logic [ST_W-1:0] b_st,
    output lvl_e            b_mode
);
    logic [XLEN-1:0] pc_q   [NUM_LVL];
    logic [XLEN-1:0] sp_q   [NUM_LVL];
    logic [ST_W-1:0] st_q   [NUM_LVL];
    lvl_e            mode_q [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_set
        // Load this level's set when the write targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[g]   <= '0;
                sp_q[g]   <= '0;
                st_q[g]   <= '0;
                mode_q[g] <= LV_USER;
            end else if (wr_en && (wr_lvl == lvl_e'(g))) begin
                pc_q[g]   <= wr_pc;
                sp_q[g]   <= wr_sp;
                st_q[g]   <= wr_st;
                mode_q[g] <= wr_mode;
            end
        end
    end

    // Inspection read port.
    always_comb begin
        a_pc   = pc_q[a_lvl];
        a_sp   = sp_q[a_lvl];
        a_st   = st_q[a_lvl];
        a_mode = mode_q[a_lvl];
    end

    // Exit read port.
    always_comb begin
        b_pc   = pc_q[b_lvl];
        b_sp   = sp_q[b_lvl];
        b_st   = st_q[b_lvl];
        b_mode = mode_q[b_lvl];
    end
endmodule

// File: rtl/irq_ctx_unit.sv
// Interrupt entry/exit context capture unit (top).
// Accepts one request per two cycles, saves the interrupted context into the
// shadow set of the delivered level, and presents the handler PC/SP/mode one
// cycle after acceptance. Exit presents the shadow set of cur_mode one cycle
// after exit_valid. Assumes the request has already been arbitrated.
module irq_ctx_unit
    import irq_ctx_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int ST_W      = 16,
    parameter int PRIO_W    = 4,
    parameter int VEC_SHIFT = 4,
    parameter logic [XLEN-1:0] BASE_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [1:0]        req_lvl,
    input  logic              req_user_ok,
    output logic              req_ready,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_sp,
    input  logic [ST_W-1:0]   cur_status,
    input  logic [1:0]        cur_mode,
    input  logic [XLEN-1:0]   priv_sp,
    input  logic              base_we,
    input  logic [XLEN-1:0]   base_wdata,
    input  logic              exit_valid,
    input  logic [1:0]        rd_lvl,
    output logic              ent_valid,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   new_sp,
    output logic [1:0]        new_mode,
    output logic              ret_valid,
    output logic [XLEN-1:0]   ret_pc,
    output logic [XLEN-1:0]   ret_sp,
    output logic [ST_W-1:0]   ret_status,
    output logic [1:0]        ret_mode,
    output logic [XLEN-1:0]   rd_pc,
    output logic [XLEN-1:0]   rd_sp,
    output logic [ST_W-1:0]   rd_status,
    output logic [1:0]        rd_mode
);
    lvl_e            mode_now, dlv_lvl, rd_sel, rd_m, ex_m;
    logic            accept, keep_user, sp_switch;
    logic [XLEN-1:0] vec_pc, vec_base, ex_pc, ex_sp;
    logic [ST_W-1:0] ex_st;

    // Decode the live mode and selections into the level type.
    always_comb begin
        mode_now = lvl_e'(cur_mode);
        rd_sel   = lvl_e'(rd_lvl);
    end

    // Acceptance and delivery decision.
    always_comb begin
        req_ready = !ent_valid;
        accept    = req_valid && req_ready;
        keep_user = req_user_ok && (mode_now == LV_USER);
        dlv_lvl   = keep_user ? LV_USER : lvl_e'(req_lvl);
        sp_switch = (mode_now == LV_USER) && (dlv_lvl != LV_USER);
    end

    irq_vec_gen #(
        .XLEN(XLEN), .PRIO_W(PRIO_W), .VEC_SHIFT(VEC_SHIFT), .BASE_RST(BASE_RST)
    ) u_vec (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .cur_mode(mode_now), .prio(req_prio), .base_q(vec_base), .vec_pc(vec_pc)
    );

    irq_ctx_bank #(.XLEN(XLEN), .ST_W(ST_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_lvl(dlv_lvl), .wr_pc(cur_pc), .wr_sp(cur_sp),
        .wr_st(cur_status), .wr_mode(mode_now),
        .a_lvl(rd_sel), .a_pc(rd_pc), .a_sp(rd_sp), .a_st(rd_status), .a_mode(rd_m),
        .b_lvl(mode_now), .b_pc(ex_pc), .b_sp(ex_sp), .b_st(ex_st), .b_mode(ex_m)
    );

    always_comb rd_mode = rd_m;

    // Entry outputs, valid for one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= 1'b0;
            new_pc    <= '0;
            new_sp    <= '0;
            new_mode  <= '0;
        end else begin
            ent_valid <= accept;
            if (accept) begin
                new_pc   <= vec_pc;
                new_sp   <= sp_switch ? priv_sp : cur_sp;
                new_mode <= dlv_lvl;
            end
        end
    end

    // Exit outputs, restoring the shadow set of the current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid  <= 1'b0;
            ret_pc     <= '0;
            ret_sp     <= '0;
            ret_status <= '0;
            ret_mode   <= '0;
        end else begin
            ret_valid <= exit_valid;
            if (exit_valid) begin
                ret_pc     <= ex_pc;
                ret_sp     <= ex_sp;
                ret_status <= ex_st;
                ret_mode   <= ex_m;
            end
        end
    end
endmodule

// File: rtl/irq_ctx_chk.sv
// Protocol checker for irq_ctx_unit, bound to every instance of it.
// Observes ports plus the vector base; holds no state of its own.
module irq_ctx_chk #(
    parameter int XLEN      = 32,
    parameter int PRIO_W    = 4,
    parameter int VEC_SHIFT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [PRIO_W-1:0] req_prio,
    input logic              req_user_ok,
    input logic [1:0]        cur_mode,
    input logic [XLEN-1:0]   cur_sp,
    input logic              base_we,
    input logic [XLEN-1:0]   vec_base,
    input logic              exit_valid,
    input logic              ent_valid,
    input logic [XLEN-1:0]   new_pc,
    input logic [XLEN-1:0]   new_sp,
    input logic [1:0]        new_mode,
    input logic              ret_valid
);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ent_valid);
    // R2
    ent_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |=> !ent_valid);
    // R3
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> new_pc == $past(vec_base) + (XLEN'($past(req_prio)) << VEC_SHIFT));
    // R4
    base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(base_we && cur_mode == 2'd1) |=> $stable(vec_base));
    // R5
    sp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && $past(cur_mode) != 2'd0) |-> new_sp == $past(cur_sp));
    // R6
    self_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && $past(req_user_ok) && $past(cur_mode) == 2'd0)
        |-> (new_mode == 2'd0 && new_sp == $past(cur_sp)));
    // R9
    exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> ret_valid);
    // R9
    exit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exit_valid |=> !ret_valid);
endmodule

bind irq_ctx_unit irq_ctx_chk #(
    .XLEN(XLEN), .PRIO_W(PRIO_W), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_prio(req_prio), .req_user_ok(req_user_ok), .cur_mode(cur_mode),
    .cur_sp(cur_sp), .base_we(base_we), .vec_base(vec_base),
    .exit_valid(exit_valid), .ent_valid(ent_valid), .new_pc(new_pc),
    .new_sp(new_sp), .new_mode(new_mode), .ret_valid(ret_valid)
);

// File: tb/irq_ctx_unit_tb.sv
// Directed bench for irq_ctx_unit: one task per scenario, each self-checking.
module irq_ctx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_user_ok = 0, base_we = 0, exit_valid = 0;
    logic [3:0]  req_prio = 0;
    logic [1:0]  req_lvl = 0, cur_mode = 0, rd_lvl = 0;
    logic [31:0] cur_pc = 0, cur_sp = 0, priv_sp = 0, base_wdata = 0;
    logic [15:0] cur_status = 0;
    logic        req_ready, ent_valid, ret_valid;
    logic [31:0] new_pc, new_sp, ret_pc, ret_sp, rd_pc, rd_sp;
    logic [1:0]  new_mode, ret_mode, rd_mode;
    logic [15:0] ret_status, rd_status;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_ctx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
        .req_lvl(req_lvl), .req_user_ok(req_user_ok), .req_ready(req_ready),
        .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_status(cur_status),
        .cur_mode(cur_mode), .priv_sp(priv_sp), .base_we(base_we),
        .base_wdata(base_wdata), .exit_valid(exit_valid), .rd_lvl(rd_lvl),
        .ent_valid(ent_valid), .new_pc(new_pc), .new_sp(new_sp),
        .new_mode(new_mode), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_sp(ret_sp), .ret_status(ret_status), .ret_mode(ret_mode),
        .rd_pc(rd_pc), .rd_sp(rd_sp), .rd_status(rd_status), .rd_mode(rd_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ctx(input logic [1:0] m, input logic [31:0] pc,
                           input logic [31:0] sp, input logic [15:0] st);
        cur_mode = m; cur_pc = pc; cur_sp = sp; cur_status = st;
    endtask

    // Pulse a request for one edge; outputs are checked by the caller at return.
    task automatic entry(input logic [3:0] p, input logic [1:0] lvl, input logic uok);
        @(negedge clk);
        req_valid = 1; req_prio = p; req_lvl = lvl; req_user_ok = uok;
        @(posedge clk); #1;
    endtask

    task automatic entry_end();
        @(negedge clk); req_valid = 0; req_user_ok = 0;
        @(posedge clk); #1;
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk); base_we = 1; base_wdata = v;
        @(negedge clk); base_we = 0;
    endtask

    task automatic t_reset();
        chk("R1 req_ready", {31'b0, req_ready}, 1);
        chk("R1 ent_valid", {31'b0, ent_valid}, 0);
        chk("R1 ret_valid", {31'b0, ret_valid}, 0);
        rd_lvl = 2; #1;
        chk("R1 rd_pc", rd_pc, 0);
        chk("R1 rd_sp", rd_sp, 0);
    endtask

    task automatic t_vector();
        set_ctx(2'd1, 32'h400, 32'h7000, 16'h11);
        write_base(32'h1000);
        entry(4'd5, 2'd1, 1'b0);
        chk("R3 new_pc prio5", new_pc, 32'h1050);
        chk("R5 new_sp super", new_sp, 32'h7000);
        chk("R6 new_mode", {30'b0, new_mode}, 1);
        entry_end();
        entry(4'd15, 2'd1, 1'b0);
        chk("R3 new_pc prio15", new_pc, 32'h10F0);
        entry_end();
    endtask

    task automatic t_base_ignored();
        set_ctx(2'd0, 32'h0, 32'h0, 16'h0);
        write_base(32'h8000);
        set_ctx(2'd2, 32'h900, 32'h6600, 16'h3);
        write_base(32'h9000);
        entry(4'd0, 2'd3, 1'b0);
        chk("R4 base unchanged", new_pc, 32'h1000);
        chk("R5 new_sp hyper", new_sp, 32'h6600);
        entry_end();
    endtask

    task automatic t_user_switch();
        set_ctx(2'd0, 32'h2222, 32'h3000, 16'h5);
        priv_sp = 32'hA000;
        entry(4'd2, 2'd1, 1'b0);
        chk("R5 switched sp", new_sp, 32'hA000);
        chk("R3 new_pc prio2", new_pc, 32'h1020);
        chk("R6 new_mode", {30'b0, new_mode}, 1);
        rd_lvl = 1; #1;
        chk("R7 saved pc", rd_pc, 32'h2222);
        chk("R7 saved sp", rd_sp, 32'h3000);
        chk("R7 saved status", {16'b0, rd_status}, 5);
        chk("R7 saved mode", {30'b0, rd_mode}, 0);
        entry_end();
    endtask

    task automatic t_user_self();
        set_ctx(2'd0, 32'h2400, 32'h3100, 16'h7);
        entry(4'd1, 2'd1, 1'b1);
        chk("R6 self mode", {30'b0, new_mode}, 0);
        chk("R6 self sp", new_sp, 32'h3100);
        rd_lvl = 0; #1;
        chk("R7 user set pc", rd_pc, 32'h2400);
        rd_lvl = 1; #1;
        chk("R8 super set kept", rd_pc, 32'h2222);
        entry_end();
    endtask

    task automatic t_nested();
        set_ctx(2'd1, 32'h5000, 32'hA100, 16'h22);
        entry(4'd3, 2'd2, 1'b1);
        chk("R6 user_ok ignored", {30'b0, new_mode}, 2);
        chk("R5 nested sp", new_sp, 32'hA100);
        rd_lvl = 2; #1;
        chk("R7 hyper set pc", rd_pc, 32'h5000);
        chk("R7 hyper set mode", {30'b0, rd_mode}, 1);
        rd_lvl = 1; #1;
        chk("R8 super set kept", rd_pc, 32'h2222);
        chk("R8 super set sp kept", rd_sp, 32'h3000);
        entry_end();
    endtask

    task automatic t_handshake();
        set_ctx(2'd3, 32'h77, 32'h88, 16'h1);
        @(negedge clk);
        req_valid = 1; req_prio = 4'd0; req_lvl = 2'd3;
        @(posedge clk); #1;
        chk("R2 first accept", {31'b0, ent_valid}, 1);
        chk("R2 ready low", {31'b0, req_ready}, 0);
        @(posedge clk); #1;
        chk("R2 busy edge skipped", {31'b0, ent_valid}, 0);
        @(posedge clk); #1;
        chk("R2 second accept", {31'b0, ent_valid}, 1);
        entry_end();
        chk("R2 idle", {31'b0, ent_valid}, 0);
    endtask

    task automatic t_exit();
        set_ctx(2'd2, 32'h0, 32'h0, 16'h0);
        @(negedge clk); exit_valid = 1;
        @(posedge clk); #1;
        chk("R9 ret_valid", {31'b0, ret_valid}, 1);
        chk("R9 ret_pc", ret_pc, 32'h5000);
        chk("R9 ret_sp", ret_sp, 32'hA100);
        chk("R9 ret_status", {16'b0, ret_status}, 32'h22);
        chk("R9 ret_mode", {30'b0, ret_mode}, 1);
        @(negedge clk); exit_valid = 0;
        @(posedge clk); #1;
        chk("R9 ret_valid drop", {31'b0, ret_valid}, 0);
    endtask

    task automatic t_collide();
        set_ctx(2'd1, 32'h6000, 32'hB000, 16'h33);
        @(negedge clk);
        exit_valid = 1; req_valid = 1; req_prio = 4'd1; req_lvl = 2'd1;
        @(posedge clk); #1;
        chk("R10 ret old pc", ret_pc, 32'h2222);
        chk("R10 ret old sp", ret_sp, 32'h3000);
        chk("R10 ret old mode", {30'b0, ret_mode}, 0);
        chk("R10 entry pc", new_pc, 32'h1010);
        rd_lvl = 1; #1;
        chk("R10 set now new pc", rd_pc, 32'h6000);
        chk("R10 set now new mode", {30'b0, rd_mode}, 1);
        @(negedge clk); exit_valid = 0;
        entry_end();
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        t_reset();
        t_vector();
        t_base_ignored();
        t_user_switch();
        t_user_self();
        t_nested();
        t_handshake();
        t_exit();
        t_collide();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule